// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit up-counters, all clocked from the same input clock. Software reaches every channel through one flat 32-bit register port. The block is typically used as a system tick source. One channel free-runs as a timebase. Another channel is set to a limit and raises its interrupt line each time the count passes that limit and returns to zero.

Each channel has the following controls:
- a clock-control word that can slow the count with a power-of-two divider;
- a counter-control word that stops or runs the counter, selects limit (interval) mode, and can zero the count with a write-only strobe;
- a limit register and three spare compare registers;
- a one-bit event flag and a one-bit interrupt enable.

The flag stays set until software clears it. Software clears it either by reading it or by writing a 1 back to it.

Registers are grouped into banks by function. The three channels sit side by side inside each bank at a 4-byte stride. The banks follow each other at a 12-byte stride. A read returns its data on the clock edge that follows the read request.

Top module: `trio_timer`

## Requirements
- R1: After reset every channel is stopped with a count of 0, every irq bit is low, and counter control reads 0x01.
- R2: The byte address is (bank*3 + channel)*4. Banks are 0 clock control, 1 counter control, 2 count, 3 limit, 4..6 compare A/B/C, 7 event flag and 8 interrupt enable. Limit and compare registers keep 16 bits. Addresses at or above 0x6C read 0. rdata is valid in the cycle after rdEn.
- R3: Counter-control bit 0 = 1 stops the counter and holds its value. With bit 0 = 0 the counter advances by one on each tick.
- R4: Writing counter control with bit 4 set zeroes the count and the divider phase at that write's edge, even while the counter is stopped. Bit 4 always reads back 0.
- R5: With counter-control bit 1 = 1 (limit mode) and limit L, the count runs 0..L, then returns to 0 and sets the event flag. Without the divider, this happens on the (L+1)th edge after the write that starts the count.
- R6: With bit 1 = 0 the count runs freely from 0xFFFF to 0 and never sets the event flag.
- R7: Clock-control bit 0 enables the divider and bits 4:1 hold N. A tick then occurs every 2^(N+1) clocks, so with limit L the flag sets (L+1)*2^(N+1) edges after the start write.
- R8: Flag bit 0 reads 1 after an event. The read returns the value and clears the flag. Writing 1 to flag bit 0 also clears it. An event in the same cycle as a clear keeps the flag set.
- R9: irq[k] is the channel's flag ANDed with bit 0 of its interrupt enable.
- R10: Writes to the count bank are ignored.
- R11: Activity on one channel never changes another channel's count, flag or irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared input clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | 3 | One interrupt line per channel |

## Verification
The limit-mode function is tried with four patterns:
- a small limit with no divider, which pins the exact edge of the wrap;
- a limit of zero, which sets the flag on every tick;
- divider settings N=0 and N=1 on other channels, which separate a correct 2^(N+1) rate from the off-by-one rates 2^N and 2^(N+2);
- a free-running count carried through 0xFFFF, which tells a correct 16-bit wrap apart from a false limit event.

Stop and restart patterns separate a hold from a clear. A zero-limit run that is read while it keeps counting shows whether the event wins over the clear-on-read.

// File: rtl/trio_pkg.sv
package trio_pkg;
  localparam int CNT_W = 16;
  localparam int SEL_W = 4;
  localparam int PRE_W = 1 << SEL_W;
  localparam int NBANK = 9;

  typedef enum logic [3:0] {
    BK_CLK = 4'd0, BK_CTL = 4'd1, BK_CNT = 4'd2, BK_LIM = 4'd3,
    BK_CMA = 4'd4, BK_CMB = 4'd5, BK_CMC = 4'd6, BK_FLG = 4'd7,
    BK_IEN = 4'd8, BK_NONE = 4'd15
  } bank_e;

  // strobes and settings from control to datapath, one per channel
  typedef struct packed {
    logic run;
    logic limMode;
    logic divEn;
    logic [SEL_W-1:0] divSel;
    logic [CNT_W-1:0] limit;
    logic restart;
  } chanCmd_t;
endpackage

// File: rtl/trio_core.sv
module trio_core
  import trio_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic clk,
  input  logic rstN,
  input  chanCmd_t [NCH-1:0] cmd,
  output logic [NCH-1:0][CNT_W-1:0] count,
  output logic [NCH-1:0] evt
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [PRE_W-1:0] divCnt;
    logic [PRE_W-1:0] divMask;
    logic [CNT_W-1:0] cntQ;
    logic tick;
    logic wrapNow;

    always_comb begin
      for (int i = 0; i < PRE_W; i++) begin
        divMask[i] = (SEL_W'(i) <= cmd[k].divSel);
      end
    end

    assign tick = cmd[k].run && (!cmd[k].divEn || ((divCnt & divMask) == divMask));
    assign wrapNow = tick && cmd[k].limMode && (cntQ == cmd[k].limit);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
        divCnt <= '0;
      end else if (cmd[k].restart) begin
        cntQ <= '0;
        divCnt <= '0;
      end else if (cmd[k].run) begin
        divCnt <= tick ? '0 : divCnt + 1'b1;
        if (tick) cntQ <= wrapNow ? '0 : cntQ + 1'b1;
      end
    end

    assign count[k] = cntQ;
    assign evt[k] = wrapNow && !cmd[k].restart;
  end
endmodule

// File: rtl/trio_regs.sv
module trio_regs
  import trio_pkg::*;
#(
  parameter int NCH = 3,
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [NCH-1:0][CNT_W-1:0] count,
  input  logic [NCH-1:0] evt,
  output chanCmd_t [NCH-1:0] cmd,
  output logic [NCH-1:0] irq
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int WORDS = NBANK * NCH;

  logic [ADDR_W-3:0] word;
  logic hit;
  bank_e bankSel;
  logic [CH_W-1:0] chSel;
  logic [NCH-1:0][31:0] rdVal;
  logic unusedBits;

  assign word = addr[ADDR_W-1:2];
  assign unusedBits = &{1'b0, addr[1:0], wdata[31:CNT_W]};

  always_comb begin
    hit = (32'(word) < WORDS);
    bankSel = hit ? bank_e'(4'(32'(word) / NCH)) : BK_NONE;
    chSel = CH_W'(32'(word) % NCH);
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [SEL_W:0] clkReg;
    logic [5:0] ctlReg;
    logic [CNT_W-1:0] limReg;
    logic [2:0][CNT_W-1:0] cmpReg;
    logic flgReg;
    logic ienReg;
    logic wrHit;
    logic rdHit;
    logic [31:0] rdLocal;

    assign wrHit = wrEn && hit && (chSel == CH_W'(k));
    assign rdHit = rdEn && hit && (chSel == CH_W'(k));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        clkReg <= '0;
        ctlReg <= 6'h01;
        limReg <= '0;
        cmpReg <= '0;
        flgReg <= 1'b0;
        ienReg <= 1'b0;
      end else begin
        if (wrHit) begin
          case (bankSel)
            BK_CLK: clkReg <= wdata[SEL_W:0];
            BK_CTL: ctlReg <= {wdata[5], 1'b0, wdata[3:0]};
            BK_LIM: limReg <= wdata[CNT_W-1:0];
            BK_CMA: cmpReg[0] <= wdata[CNT_W-1:0];
            BK_CMB: cmpReg[1] <= wdata[CNT_W-1:0];
            BK_CMC: cmpReg[2] <= wdata[CNT_W-1:0];
            BK_IEN: ienReg <= wdata[0];
            default: ;
          endcase
        end
        if (evt[k]) flgReg <= 1'b1;
        else if ((rdHit && bankSel == BK_FLG) || (wrHit && bankSel == BK_FLG && wdata[0]))
          flgReg <= 1'b0;
      end
    end

    always_comb begin
      case (bankSel)
        BK_CLK: rdLocal = 32'(clkReg);
        BK_CTL: rdLocal = 32'(ctlReg);
        BK_CNT: rdLocal = 32'(count[k]);
        BK_LIM: rdLocal = 32'(limReg);
        BK_CMA: rdLocal = 32'(cmpReg[0]);
        BK_CMB: rdLocal = 32'(cmpReg[1]);
        BK_CMC: rdLocal = 32'(cmpReg[2]);
        BK_FLG: rdLocal = 32'(flgReg);
        BK_IEN: rdLocal = 32'(ienReg);
        default: rdLocal = '0;
      endcase
    end

    assign rdVal[k] = rdLocal;
    assign irq[k] = flgReg & ienReg;
    assign cmd[k] = '{
      run:     !ctlReg[0],
      limMode: ctlReg[1],
      divEn:   clkReg[0],
      divSel:  clkReg[SEL_W:1],
      limit:   limReg,
      restart: wrHit && (bankSel == BK_CTL) && wdata[4]
    };
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else if (rdEn) rdata <= hit ? rdVal[chSel] : '0;
  end
endmodule

// File: rtl/trio_timer.sv
module trio_timer
  import trio_pkg::*;
#(
  parameter int NCH = 3,
  parameter int ADDR_W = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [NCH-1:0] irq
);
  chanCmd_t [NCH-1:0] cmd;
  logic [NCH-1:0][CNT_W-1:0] count;
  logic [NCH-1:0] evt;

  trio_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .count(count), .evt(evt),
    .cmd(cmd), .irq(irq)
  );

  trio_core #(.NCH(NCH)) u_core (
    .clk(clk), .rstN(rstN), .cmd(cmd), .count(count), .evt(evt)
  );
endmodule

// File: rtl/trio_timer_chk.sv
module trio_timer_chk
  import trio_pkg::*;
#(
  parameter int NCH = 3
) (
  input logic clk,
  input logic rstN,
  input logic wrEn,
  input logic [NCH-1:0] irq,
  input chanCmd_t [NCH-1:0] cmd,
  input logic [NCH-1:0][CNT_W-1:0] count,
  input logic [NCH-1:0] evt
);
  for (genvar k = 0; k < NCH; k++) begin : g_chk
    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!cmd[k].run && !cmd[k].restart) |=> $stable(count[k]));
    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (count[k] == $past(count[k]) || count[k] == $past(count[k]) + 1'b1 || count[k] == '0));
    // R4
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      cmd[k].restart |=> (count[k] == '0));
    // R5
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      evt[k] |=> (count[k] == '0));
    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[k]) |-> ($past(evt[k]) || $past(wrEn)));
  end
endmodule

bind trio_timer trio_timer_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .irq(irq),
  .cmd(cmd), .count(count), .evt(evt)
);

// File: tb/trio_timer_test.sv
module trio_timer_test;
  localparam int B_CLK = 0, B_CTL = 1, B_CNT = 2, B_LIM = 3, B_CMA = 4;
  localparam int B_CMC = 6, B_FLG = 7, B_IEN = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0] irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  trio_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] ra(input int bank, input int ch);
    return 8'((bank * 3 + ch) * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rdEn = 1'b1;
    @(posedge clk); #1;
    rdEn = 1'b0;
    d = rdata;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", 32'(irq), 0);
    rd(ra(B_CTL, 0), v); chk("R1 ctl", v, 32'h01);
    for (int c = 0; c < 3; c++) begin
      rd(ra(B_CNT, c), v); chk("R1 count", v, 0);
    end
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(8'h28, 32'hABCD1234);
    wr(8'h50, 32'h0000BEEF);
    wr(8'h30, 32'h00005555);
    rd(8'h28, v); chk("R2 limit ch1", v, 32'h1234);
    rd(8'h50, v); chk("R2 cmpC ch2", v, 32'hBEEF);
    rd(8'h30, v); chk("R2 cmpA ch0", v, 32'h5555);
    rd(8'h24, v); chk("R2 limit ch0 no alias", v, 0);
    rd(8'h6C, v); chk("R2 unmapped", v, 0);
    wr(8'h1C, 32'h77);
    rd(8'h1C, v); chk("R10 count write ignored", v, 0);
  endtask

  task automatic runLimit(input int ch, input int lim, input bit divOn, input int n, input string req);
    int d;
    logic [31:0] v;
    d = divOn ? (1 << (n + 1)) : 1;
    wr(ra(B_IEN, ch), 1);
    wr(ra(B_LIM, ch), 32'(lim));
    wr(ra(B_CLK, ch), 32'((n << 1) | int'(divOn)));
    wr(ra(B_CTL, ch), 32'h12);
    repeat (d * (lim + 1) - 1) @(posedge clk);
    #1 chk({req, " before wrap"}, 32'(irq), 0);
    @(posedge clk); #1;
    chk({req, " R11 wrap irq only own channel"}, 32'(irq), 32'(1 << ch));
    wr(ra(B_CTL, ch), 32'h03);
    rd(ra(B_FLG, ch), v); chk("R8 flag read", v, 1);
    chk("R8 irq after read-clear", 32'(irq), 0);
    rd(ra(B_FLG, ch), v); chk("R8 flag cleared", v, 0);
  endtask

  task automatic t_holdRestart();
    logic [31:0] v1, v2;
    rd(ra(B_CNT, 0), v1);
    repeat (5) @(posedge clk); #1;
    rd(ra(B_CNT, 0), v2); chk("R3 stopped holds", v2, v1);
    wr(ra(B_CTL, 0), 32'h13);
    rd(ra(B_CNT, 0), v1); chk("R4 restart while stopped", v1, 0);
    rd(ra(B_CTL, 0), v1); chk("R4 bit4 reads 0", v1, 32'h03);
    wr(ra(B_CLK, 0), 0);
    wr(ra(B_LIM, 0), 3);
    wr(ra(B_CTL, 0), 32'h10);
    repeat (9) @(posedge clk); #1;
    wr(ra(B_CTL, 0), 32'h01);
    rd(ra(B_CNT, 0), v1); chk("R3 step count", v1, 10);
    rd(ra(B_FLG, 0), v1); chk("R6 no flag outside limit mode", v1, 0);
    wr(ra(B_CTL, 0), 32'h10);
    repeat (65535) @(posedge clk); #1;
    wr(ra(B_CTL, 0), 32'h01);
    rd(ra(B_CNT, 0), v1); chk("R6 wrap past 0xFFFF", v1, 0);
    rd(ra(B_FLG, 0), v1); chk("R6 flag after wrap", v1, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(ra(B_IEN, 2), 0);
    wr(ra(B_CLK, 2), 0);
    wr(ra(B_LIM, 2), 1);
    wr(ra(B_CTL, 2), 32'h12);
    repeat (4) @(posedge clk); #1;
    chk("R9 masked irq low", 32'(irq), 0);
    wr(ra(B_CTL, 2), 32'h03);
    wr(ra(B_IEN, 2), 1);
    chk("R9 irq after enable", 32'(irq), 32'h4);
    wr(ra(B_FLG, 2), 1);
    chk("R8 write-back clear irq", 32'(irq), 0);
    rd(ra(B_FLG, 2), v); chk("R8 write-back cleared flag", v, 0);
  endtask

  task automatic t_setWins();
    logic [31:0] v;
    wr(ra(B_IEN, 0), 1);
    wr(ra(B_LIM, 0), 0);
    wr(ra(B_CTL, 0), 32'h12);
    @(posedge clk); #1;
    rd(ra(B_FLG, 0), v); chk("R8 flag set while running", v, 1);
    chk("R8 event beats read-clear", 32'(irq), 32'h1);
    wr(ra(B_CTL, 0), 32'h03);
    rd(ra(B_FLG, 0), v);
    rd(ra(B_FLG, 0), v); chk("R8 cleared once stopped", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_map();
    runLimit(0, 5, 1'b0, 0, "R5 limit 5");
    runLimit(0, 0, 1'b0, 0, "R5 limit 0");
    runLimit(1, 3, 1'b1, 0, "R7 div N=0");
    runLimit(2, 2, 1'b1, 1, "R7 div N=1");
    t_holdRestart();
    t_mask();
    t_setWins();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end
endmodule